// File: doc/BRIEF.md
# Hit-Selecting Trigger Frame Packer

The block gathers hit reports from 32 channel deserializer units and turns them into one fixed-width frame for a wide serial-link transmitter. Every report slot carries a valid flag, a 6-bit address and a parity bit. When the frame strobe is raised, a fixed-priority selector picks at most eight reporting channels. The lowest channel number wins first. The block then writes the channel number, address and parity of each winner into its own slot of a 112-bit frame, with a saturating hit count in front.

The output is registered. The frame appears, with its valid flag, on the cycle after the strobe. It holds its value until the next strobe. A strobe with no active channel still produces a frame, whose every bit is zero.

Top module: `trig_frame_packer`

## Requirements
- R1: `frame_vld_o` is high for exactly the one cycle after each cycle in which `frame_strobe_i` is high, and low otherwise; one frame is produced per strobe.
- R2: Frame bits [3:0] hold the hit count, equal to the number of active channels at the strobe, saturated at 8; codes 9 to 15 never appear.
- R3: Winners are ordered by channel index, the lowest active channel in slot 0. Slot k (0 to 7) holds its 5-bit channel number at bits [4+5k +: 5].
- R4: Slot k holds the 6-bit address reported by its winning channel at bits [52+6k +: 6].
- R5: Slot k holds the parity bit reported by its winning channel at bit 44+k.
- R6: Active channels beyond the eighth in index order are dropped and leave no trace in the frame.
- R7: Slots at or above the hit count have zero channel number, address and parity, and bits [111:100] are always zero.
- R8: A strobe with no active channel yields a valid frame that is all zero.
- R9: After a synchronous reset, `frame_o` is zero and `frame_vld_o` is low.
- R10: While the strobe is low, `frame_o` keeps its last value whatever the report inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe_i | input | 1 | Build a frame from the reports present in this cycle |
| ch_valid_i | input | 32 | Per-channel hit report valid, bit c for channel c |
| ch_addr_i | input | 192 | Per-channel 6-bit address, channel c at [6c +: 6] |
| ch_par_i | input | 32 | Per-channel parity bit, bit c for channel c |
| frame_o | output | 112 | Packed output frame |
| frame_vld_o | output | 1 | Frame valid, one cycle after the strobe |

## Verification
The bench applies several input patterns, and each one separates a different kind of fault. An empty pattern and a lone channel 31 show whether the count and the zero fill of unused slots are correct. The low eight channels alone, exactly eight sparse channels, and nine or thirty-two active channels show whether the count saturates and whether losers are dropped at the eighth winner. Distinct per-channel addresses and parities, random patterns sent back to back, and input changes between strobes show whether fields are swapped between slots or leak in while the frame should hold.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  parameter int unsigned TFP_NUM_CH    = 32;
  parameter int unsigned TFP_NUM_SLOTS = 8;
  parameter int unsigned TFP_ADDR_W    = 6;
  parameter int unsigned TFP_CNT_W     = 4;
  parameter int unsigned TFP_FRAME_W   = 112;

  // Saturate a running hit count to the number of slots.
  function automatic int unsigned tfp_sat(input int unsigned n, input int unsigned lim);
    return (n > lim) ? lim : n;
  endfunction
endpackage

// File: rtl/tfp_hit_selector.sv
module tfp_hit_selector #(
  parameter int unsigned NUM_CH    = tfp_pkg::TFP_NUM_CH,
  parameter int unsigned NUM_SLOTS = tfp_pkg::TFP_NUM_SLOTS,
  parameter int unsigned ADDR_W    = tfp_pkg::TFP_ADDR_W,
  parameter int unsigned CNT_W     = tfp_pkg::TFP_CNT_W,
  localparam int unsigned ID_W     = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]           ch_valid,
  input  logic [NUM_CH*ADDR_W-1:0]    ch_addr,
  input  logic [NUM_CH-1:0]           ch_par,
  output logic [NUM_SLOTS*ID_W-1:0]   slot_id,
  output logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
  output logic [NUM_SLOTS-1:0]        slot_par,
  output logic [CNT_W-1:0]            hit_cnt
);
  // Each active channel takes the slot given by the number of active
  // channels below it; ranks of NUM_SLOTS and above are dropped.
  always_comb begin : rank_walk
    int rank;
    rank      = 0;
    slot_id   = '0;
    slot_addr = '0;
    slot_par  = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (ch_valid[ch]) begin
        if (rank < NUM_SLOTS) begin
          slot_id[rank*ID_W +: ID_W]       = ID_W'(ch);
          slot_addr[rank*ADDR_W +: ADDR_W] = ch_addr[ch*ADDR_W +: ADDR_W];
          slot_par[rank]                   = ch_par[ch];
        end
        rank = rank + 1;
      end
    end
    hit_cnt = CNT_W'(tfp_pkg::tfp_sat(rank, NUM_SLOTS));
  end
endmodule

// File: rtl/tfp_frame_assembler.sv
module tfp_frame_assembler #(
  parameter int unsigned NUM_CH    = tfp_pkg::TFP_NUM_CH,
  parameter int unsigned NUM_SLOTS = tfp_pkg::TFP_NUM_SLOTS,
  parameter int unsigned ADDR_W    = tfp_pkg::TFP_ADDR_W,
  parameter int unsigned CNT_W     = tfp_pkg::TFP_CNT_W,
  parameter int unsigned FRAME_W   = tfp_pkg::TFP_FRAME_W,
  localparam int unsigned ID_W     = $clog2(NUM_CH),
  localparam int unsigned ID_LSB   = CNT_W,
  localparam int unsigned PAR_LSB  = ID_LSB + NUM_SLOTS*ID_W,
  localparam int unsigned ADR_LSB  = PAR_LSB + NUM_SLOTS,
  localparam int unsigned USED_W   = ADR_LSB + NUM_SLOTS*ADDR_W
) (
  input  logic [NUM_SLOTS*ID_W-1:0]   slot_id,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
  input  logic [NUM_SLOTS-1:0]        slot_par,
  input  logic [CNT_W-1:0]            hit_cnt,
  output logic [FRAME_W-1:0]          frame
);
  if (USED_W > FRAME_W) begin : g_bad_width
    initial $error("frame fields do not fit the frame width");
  end

  always_comb begin
    frame = '0;
    frame[0 +: CNT_W]                    = hit_cnt;
    frame[ID_LSB +: NUM_SLOTS*ID_W]      = slot_id;
    frame[PAR_LSB +: NUM_SLOTS]          = slot_par;
    frame[ADR_LSB +: NUM_SLOTS*ADDR_W]   = slot_addr;
  end
endmodule

// File: rtl/trig_frame_packer.sv
module trig_frame_packer #(
  parameter int unsigned NUM_CH    = tfp_pkg::TFP_NUM_CH,
  parameter int unsigned NUM_SLOTS = tfp_pkg::TFP_NUM_SLOTS,
  parameter int unsigned ADDR_W    = tfp_pkg::TFP_ADDR_W,
  parameter int unsigned CNT_W     = tfp_pkg::TFP_CNT_W,
  parameter int unsigned FRAME_W   = tfp_pkg::TFP_FRAME_W,
  localparam int unsigned ID_W     = $clog2(NUM_CH),
  localparam int unsigned ID_LSB   = CNT_W,
  localparam int unsigned PAR_LSB  = ID_LSB + NUM_SLOTS*ID_W,
  localparam int unsigned ADR_LSB  = PAR_LSB + NUM_SLOTS,
  localparam int unsigned USED_W   = ADR_LSB + NUM_SLOTS*ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_strobe_i,
  input  logic [NUM_CH-1:0]          ch_valid_i,
  input  logic [NUM_CH*ADDR_W-1:0]   ch_addr_i,
  input  logic [NUM_CH-1:0]          ch_par_i,
  output logic [FRAME_W-1:0]         frame_o,
  output logic                       frame_vld_o
);
  logic [NUM_SLOTS*ID_W-1:0]   sel_id;
  logic [NUM_SLOTS*ADDR_W-1:0] sel_addr;
  logic [NUM_SLOTS-1:0]        sel_par;
  logic [CNT_W-1:0]            sel_cnt;
  logic [FRAME_W-1:0]          frame_d;
  logic [FRAME_W-1:0]          frame_q;
  logic                        vld_q;

  tfp_hit_selector #(
    .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_sel (
    .ch_valid (ch_valid_i),
    .ch_addr  (ch_addr_i),
    .ch_par   (ch_par_i),
    .slot_id  (sel_id),
    .slot_addr(sel_addr),
    .slot_par (sel_par),
    .hit_cnt  (sel_cnt)
  );

  tfp_frame_assembler #(
    .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .FRAME_W(FRAME_W)
  ) u_asm (
    .slot_id  (sel_id),
    .slot_addr(sel_addr),
    .slot_par (sel_par),
    .hit_cnt  (sel_cnt),
    .frame    (frame_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= frame_strobe_i;
      if (frame_strobe_i) frame_q <= frame_d;
    end
  end

  assign frame_o     = frame_q;
  assign frame_vld_o = vld_q;

  // R1
  vld_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    frame_strobe_i |=> frame_vld_o);
  // R1
  vld_only_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_strobe_i |=> !frame_vld_o);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o[CNT_W-1:0] <= CNT_W'(NUM_SLOTS));
  // R2
  cnt_matches_active_chk: assert property (@(posedge clk) disable iff (rst)
    frame_strobe_i && ($countones(ch_valid_i) <= NUM_SLOTS)
    |=> frame_o[CNT_W-1:0] == CNT_W'($countones($past(ch_valid_i))));
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o[FRAME_W-1:USED_W] == '0);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_strobe_i |=> $stable(frame_o));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
    // R7
    unused_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_o[CNT_W-1:0] <= CNT_W'(s)) |->
        (frame_o[ID_LSB+s*ID_W +: ID_W] == '0) &&
        (frame_o[ADR_LSB+s*ADDR_W +: ADDR_W] == '0) &&
        !frame_o[PAR_LSB+s]);
  end
endmodule

// File: tb/tb_trig_frame_packer.sv
`timescale 1ns/1ps
module tb_trig_frame_packer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int NSL = 8;
  localparam int AW  = 6;
  localparam int FW  = 112;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            strobe = 1'b0;
  logic [NCH-1:0]  vld = '0;
  logic [NCH*AW-1:0] addr = '0;
  logic [NCH-1:0]  par = '0;
  logic [FW-1:0]   frame;
  logic            frame_vld;

  int checks = 0;
  int errors = 0;
  logic [FW-1:0] exp_q[$];
  string         tag_q[$];
  logic [FW-1:0] last_frame = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_frame_packer dut (
    .clk(clk), .rst(rst), .frame_strobe_i(strobe),
    .ch_valid_i(vld), .ch_addr_i(addr), .ch_par_i(par),
    .frame_o(frame), .frame_vld_o(frame_vld)
  );

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected frame from the requirements: count [3:0], id k at 4+5k,
  // parity k at 44+k, address k at 52+6k, rest zero.
  function automatic logic [FW-1:0] model(input logic [NCH-1:0] v, input logic [NCH*AW-1:0] a, input logic [NCH-1:0] p);
    logic [FW-1:0] f = '0;
    int n = 0;
    for (int c = 0; c < NCH; c++) begin
      if (v[c]) begin
        if (n < NSL) begin
          f[4+5*n +: 5]  = 5'(c);
          f[44+n]        = p[c];
          f[52+6*n +: 6] = a[c*AW +: AW];
        end
        n++;
      end
    end
    f[3:0] = 4'((n > NSL) ? NSL : n);
    return f;
  endfunction

  // Driver: apply reports with the strobe for one cycle, push expectation.
  task automatic send(input logic [NCH-1:0] v, input logic [NCH*AW-1:0] a, input logic [NCH-1:0] p, input string tag);
    @(negedge clk);
    vld = v; addr = a; par = p; strobe = 1'b1;
    exp_q.push_back(model(v, a, p));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe = 1'b0;
    end
  endtask

  function automatic logic [NCH*AW-1:0] addr_pattern(input int seed);
    logic [NCH*AW-1:0] a;
    for (int c = 0; c < NCH; c++) a[c*AW +: AW] = 6'((c * 7 + seed) ^ 6'h2a);
    return a;
  endfunction

  // Monitor: just after each edge, compare against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (frame_vld) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected frame", {111'b0, frame_vld}, '0);
          end else begin
            logic [FW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(frame[3:0] == e[3:0] && frame[3:0] <= 4'd8, "R2 hit count", frame, e);
            chk(frame[43:4] == e[43:4], "R3 slot ids", frame, e);
            chk(frame[51:44] == e[51:44], "R5 slot parity", frame, e);
            chk(frame[99:52] == e[99:52], "R4 slot addresses", frame, e);
            chk(frame[111:100] == '0, "R7 upper bits", frame, e);
            chk(frame == e, t, frame, e);
            last_frame = e;
          end
        end else begin
          chk(exp_q.size() == 0, "R1 missing frame valid", '0, {111'b0, 1'b1});
          chk(frame == last_frame, "R10 frame hold", frame, last_frame);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NCH-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(frame == '0, "R9 reset frame", frame, '0);
    chk(frame_vld == 1'b0, "R9 reset valid", {111'b0, frame_vld}, '0);

    send('0, addr_pattern(1), '1, "R8 empty frame");
    idle(2);
    send(32'h8000_0000, addr_pattern(2), 32'h8000_0000, "R3 lone channel 31");
    idle(1);
    send(32'h0000_00ff, addr_pattern(3), 32'h0000_00a5, "R3 low eight");
    send(32'h8421_8421, addr_pattern(4), 32'hffff_0000, "R6 exactly eight sparse");
    send(32'h0000_01ff, addr_pattern(5), 32'h0000_0155, "R6 nine active drops ninth");
    send('1, addr_pattern(6), 32'h5555_5555, "R6 all 32 saturate R2");
    send(32'hf000_0001, addr_pattern(7), 32'h1000_0001, "R4 top group");
    idle(1);
    // R10: reports change while strobe is low; frame must hold
    @(negedge clk);
    vld = '1; addr = addr_pattern(9); par = '1; strobe = 1'b0;
    idle(3);
    for (int i = 0; i < 40; i++) begin
      v = $urandom;
      if (i % 3 == 0) v = v & $urandom & $urandom;
      send(v, addr_pattern(i + 11) ^ {6{$urandom}}, $urandom, "R3 random pattern");
      if (i % 4 == 3) idle(1);
    end
    idle(4);
    chk(exp_q.size() == 0, "R1 all frames delivered", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule